// File: doc/BRIEF.md
# Power-On Reset Vector Sequencer

This block controls how a simple 32-bit processor core enters and leaves its power-on reset state. Reset can come from two places. One is an active-low external pin, which passes through a synchronizer. The other is a pair of single-cycle debug commands: one pulse holds the core in reset and a later pulse releases it. While either source holds reset, the block counts clock edges. A release starts the boot sequence only if reset was held for the minimum number of edges. After a release that is too short, the core stays parked in reset.

After a valid release, the block makes two single-beat 32-bit reads over a valid/ready read port. The first read fetches the start address into the program counter. The second fetches the initial stack pointer. While reset is held, the control registers are kept at fixed start values: vector base, interrupt mask, register-bank select and floating-point status. The `runEnable` output goes high only after both vectors are loaded. Any new reset during the fetches abandons them.

Top module: `porVectorSeq`

## Requirements
- R1: While reset is active (pin low after the synchronizer, or a debug hold), `rdValid` and `runEnable` are 0, and `pcOut` and `spOut` read 0 from the next rising edge onward. `runEnable` falls in the same cycle that `rstPinN` goes low.
- R2: If `rstPinN` is held low across at least HOLD_MIN (20) rising edges, the first read starts on the third rising edge after release. If it is held low across HOLD_MIN-3 edges or fewer, the block stays in reset, issues no read and never raises `runEnable` until reset is asserted again.
- R3: The first read uses address 0x00000000 and the second uses address 0x00000004. A handshake is `rdValid` and `rdReady` both high at a rising edge. After the first handshake `pcOut` holds the returned `rdData`, and after the second handshake `spOut` holds it.
- R4: Once `rdValid` is high, it stays high with a stable `rdAddr` until a handshake occurs, for any number of wait cycles.
- R5: While reset is held and afterwards, `vbrOut` = 0x00000000, `srMaskOut` = 4'b1111, `bankBitOut` = 0 and `fpscrOut` = 0x00040001.
- R6: `runEnable` rises in the cycle after the stack-pointer handshake and not before it. It then stays high until the next reset.
- R7: A `dbgRstAssert` pulse enters the same reset state as the pin. A `dbgRstNegate` pulse sampled at least HOLD_MIN rising edges after the assert pulse starts the sequence, with the first read on the next edge. A gap one edge shorter leaves the block in reset. A low pin clears any pending debug hold.
- R8: A reset asserted during either fetch aborts the sequence. `rdValid` drops, `pcOut` and `spOut` return to 0, and `runEnable` stays low until a complete new valid reset and release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstPinN | input | 1 | External reset pin, active low, asynchronous |
| dbgRstAssert | input | 1 | One-cycle debug command that enters reset |
| dbgRstNegate | input | 1 | One-cycle debug command that releases reset |
| rdValid | output | 1 | Vector read request valid |
| rdAddr | output | 32 | Vector read address |
| rdReady | input | 1 | Memory accepts the read; `rdData` valid in the same cycle |
| rdData | input | 32 | Read data |
| pcOut | output | 32 | Program counter |
| spOut | output | 32 | Stack pointer |
| vbrOut | output | 32 | Vector base register |
| srMaskOut | output | 4 | Interrupt mask field of the status register |
| bankBitOut | output | 1 | Interrupt register-bank select bit |
| fpscrOut | output | 32 | Floating-point status/control register |
| runEnable | output | 1 | Core may execute |

## Verification
The pin path has the longest latency. Counting the edges during the low pulse plus the two synchronizer edges after release, the first read appears after the third rising edge following release. The debug path reacts one edge after a command pulse. `pcOut` is updated one edge after its handshake, while `spOut` and `runEnable` change together one edge after theirs. `runEnable` falls without waiting for a clock when the pin drops. The bench drives inputs on falling edges and lets a responder act one nanosecond after each falling edge. It compares every granted read address and every rise of `runEnable` against queued expectations, and so checks each result in the first cycle in which it can be seen.

// File: rtl/porVectorPkg.sv
package porVectorPkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned MASK_W = 4;

  localparam logic [WORD_W-1:0] PC_VEC_ADDR = 32'h0000_0000;
  localparam logic [WORD_W-1:0] SP_VEC_ADDR = 32'h0000_0004;
  localparam logic [WORD_W-1:0] VBR_INIT    = 32'h0000_0000;
  localparam logic [WORD_W-1:0] FPSCR_INIT  = 32'h0004_0001;
  localparam logic [MASK_W-1:0] MASK_INIT   = 4'hF;

  typedef enum logic [1:0] {
    ST_RESET    = 2'd0,
    ST_FETCH_PC = 2'd1,
    ST_FETCH_SP = 2'd2,
    ST_RUN      = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic holdInit;
    logic loadPc;
    logic loadSp;
  } seqStrobes_t;
endpackage

// File: rtl/porResetSync.sv
module porResetSync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstPinN,
  output logic pinLow
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain;

  // asynchronous entry, release through the flop chain
  always_ff @(posedge clk or negedge rstPinN) begin
    if (!rstPinN) chain <= '0;
    else          chain <= {chain[LAST-1:0], 1'b1};
  end

  assign pinLow = ~chain[LAST];
endmodule

// File: rtl/porVectorCtrl.sv
module porVectorCtrl
  import porVectorPkg::*;
#(
  parameter int unsigned HOLD_MIN    = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstPinN,
  input  logic              dbgRstAssert,
  input  logic              dbgRstNegate,
  input  logic              rdReady,
  output logic              rdValid,
  output logic [WORD_W-1:0] rdAddr,
  output logic              runEnable,
  output logic              inReset,
  output seqStrobes_t       strobes
);
  localparam int unsigned CNT_W = $clog2(HOLD_MIN + 1);
  localparam logic [CNT_W-1:0] HOLD_LIMIT = CNT_W'(HOLD_MIN);

  logic             pinLow;
  logic             dbgHold;
  logic [CNT_W-1:0] holdCnt;
  logic             holdMet;
  seqState_t        state, stateNxt;

  porResetSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk     (clk),
    .rstPinN (rstPinN),
    .pinLow  (pinLow)
  );

  // debug hold: pin wins, then assert, then negate
  always_ff @(posedge clk) begin
    if (pinLow)            dbgHold <= 1'b0;
    else if (dbgRstAssert) dbgHold <= 1'b1;
    else if (dbgRstNegate) dbgHold <= 1'b0;
  end

  assign inReset = pinLow | dbgHold;
  assign holdMet = (holdCnt >= HOLD_LIMIT);

  // saturating hold-time counter
  always_ff @(posedge clk) begin
    if (inReset) holdCnt <= holdMet ? holdCnt : holdCnt + 1'b1;
    else         holdCnt <= '0;
  end

  always_comb begin
    stateNxt = state;
    if (inReset) begin
      stateNxt = ST_RESET;
    end else begin
      unique case (state)
        ST_RESET:    if (holdMet) stateNxt = ST_FETCH_PC;
        ST_FETCH_PC: if (rdReady) stateNxt = ST_FETCH_SP;
        ST_FETCH_SP: if (rdReady) stateNxt = ST_RUN;
        default:     stateNxt = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) state <= stateNxt;

  assign rdValid   = ((state == ST_FETCH_PC) || (state == ST_FETCH_SP)) && !inReset;
  assign rdAddr    = (state == ST_FETCH_SP) ? SP_VEC_ADDR : PC_VEC_ADDR;
  assign runEnable = (state == ST_RUN) && !inReset;

  assign strobes.holdInit = (state == ST_RESET);
  assign strobes.loadPc   = rdValid && rdReady && (state == ST_FETCH_PC);
  assign strobes.loadSp   = rdValid && rdReady && (state == ST_FETCH_SP);
endmodule

// File: rtl/porVectorPath.sv
module porVectorPath
  import porVectorPkg::*;
(
  input  logic              clk,
  input  logic              inReset,
  input  seqStrobes_t       strobes,
  input  logic [WORD_W-1:0] rdData,
  output logic [WORD_W-1:0] pcOut,
  output logic [WORD_W-1:0] spOut,
  output logic [WORD_W-1:0] vbrOut,
  output logic [MASK_W-1:0] srMaskOut,
  output logic              bankBitOut,
  output logic [WORD_W-1:0] fpscrOut
);
  logic clearAll;

  assign clearAll = inReset | strobes.holdInit;

  always_ff @(posedge clk) begin
    if (clearAll) begin
      pcOut      <= '0;
      spOut      <= '0;
      vbrOut     <= VBR_INIT;
      srMaskOut  <= MASK_INIT;
      bankBitOut <= 1'b0;
      fpscrOut   <= FPSCR_INIT;
    end else begin
      if (strobes.loadPc) pcOut <= rdData;
      if (strobes.loadSp) spOut <= rdData;
    end
  end
endmodule

// File: rtl/porVectorSeq.sv
module porVectorSeq
  import porVectorPkg::*;
#(
  parameter int unsigned HOLD_MIN    = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstPinN,
  input  logic              dbgRstAssert,
  input  logic              dbgRstNegate,
  output logic              rdValid,
  output logic [WORD_W-1:0] rdAddr,
  input  logic              rdReady,
  input  logic [WORD_W-1:0] rdData,
  output logic [WORD_W-1:0] pcOut,
  output logic [WORD_W-1:0] spOut,
  output logic [WORD_W-1:0] vbrOut,
  output logic [MASK_W-1:0] srMaskOut,
  output logic              bankBitOut,
  output logic [WORD_W-1:0] fpscrOut,
  output logic              runEnable
);
  logic        inReset;
  seqStrobes_t strobes;

  porVectorCtrl #(.HOLD_MIN(HOLD_MIN), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk          (clk),
    .rstPinN      (rstPinN),
    .dbgRstAssert (dbgRstAssert),
    .dbgRstNegate (dbgRstNegate),
    .rdReady      (rdReady),
    .rdValid      (rdValid),
    .rdAddr       (rdAddr),
    .runEnable    (runEnable),
    .inReset      (inReset),
    .strobes      (strobes)
  );

  porVectorPath uPath (
    .clk        (clk),
    .inReset    (inReset),
    .strobes    (strobes),
    .rdData     (rdData),
    .pcOut      (pcOut),
    .spOut      (spOut),
    .vbrOut     (vbrOut),
    .srMaskOut  (srMaskOut),
    .bankBitOut (bankBitOut),
    .fpscrOut   (fpscrOut)
  );
endmodule

// File: rtl/porVectorChecker.sv
module porVectorChecker
  import porVectorPkg::*;
(
  input logic              clk,
  input logic              rstPinN,
  input logic              dbgRstAssert,
  input logic              inReset,
  input logic              rdValid,
  input logic              rdReady,
  input logic [WORD_W-1:0] rdAddr,
  input logic [WORD_W-1:0] rdData,
  input logic [WORD_W-1:0] pcOut,
  input logic [WORD_W-1:0] spOut,
  input logic [WORD_W-1:0] vbrOut,
  input logic [MASK_W-1:0] srMaskOut,
  input logic              bankBitOut,
  input logic [WORD_W-1:0] fpscrOut,
  input logic              runEnable
);
  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (!rstPinN)
    inReset |=> (pcOut == '0) && (spOut == '0));

  assert_pc_load_R3: assert property (@(posedge clk) disable iff (!rstPinN)
    (rdValid && rdReady && (rdAddr == PC_VEC_ADDR) && !dbgRstAssert)
      |=> (pcOut == $past(rdData)));

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rstPinN)
    (rdValid && !rdReady && !dbgRstAssert) |=> (rdValid && $stable(rdAddr)));

  assert_ctrl_init_R5: assert property (@(posedge clk) disable iff (!rstPinN)
    runEnable |-> ((vbrOut == VBR_INIT) && (srMaskOut == MASK_INIT) &&
                   !bankBitOut && (fpscrOut == FPSCR_INIT)));

  assert_run_after_sp_R6: assert property (@(posedge clk) disable iff (!rstPinN)
    $rose(runEnable) |-> $past(rdValid && rdReady && (rdAddr == SP_VEC_ADDR)));
endmodule

bind porVectorSeq porVectorChecker uChk (
  .clk          (clk),
  .rstPinN      (rstPinN),
  .dbgRstAssert (dbgRstAssert),
  .inReset      (inReset),
  .rdValid      (rdValid),
  .rdReady      (rdReady),
  .rdAddr       (rdAddr),
  .rdData       (rdData),
  .pcOut        (pcOut),
  .spOut        (spOut),
  .vbrOut       (vbrOut),
  .srMaskOut    (srMaskOut),
  .bankBitOut   (bankBitOut),
  .fpscrOut     (fpscrOut),
  .runEnable    (runEnable)
);

// File: tb/tb_porVectorSeq.sv
`timescale 1ns/1ps
module tb_porVectorSeq;
  logic        clk = 1'b0;
  logic        rstPinN = 1'b0;
  logic        dbgRstAssert = 1'b0;
  logic        dbgRstNegate = 1'b0;
  logic        rdValid;
  logic [31:0] rdAddr;
  logic        rdReady = 1'b0;
  logic [31:0] rdData = '0;
  logic [31:0] pcOut, spOut, vbrOut, fpscrOut;
  logic [3:0]  srMaskOut;
  logic        bankBitOut;
  logic        runEnable;

  int total = 0;
  int bad = 0;
  int delay = 0;
  logic [31:0] pcVec = '0;
  logic [31:0] spVec = '0;

  typedef struct { logic [31:0] pc; logic [31:0] sp; } bootExp_t;
  logic [31:0] expAddr[$];
  bootExp_t    expRun[$];

  always #5 clk = ~clk;

  porVectorSeq dut (
    .clk(clk), .rstPinN(rstPinN), .dbgRstAssert(dbgRstAssert), .dbgRstNegate(dbgRstNegate),
    .rdValid(rdValid), .rdAddr(rdAddr), .rdReady(rdReady), .rdData(rdData),
    .pcOut(pcOut), .spOut(spOut), .vbrOut(vbrOut), .srMaskOut(srMaskOut),
    .bankBitOut(bankBitOut), .fpscrOut(fpscrOut), .runEnable(runEnable)
  );

  task automatic chkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic logic [31:0] memWord(input logic [31:0] a);
    if (a == 32'h0) return pcVec;
    if (a == 32'h4) return spVec;
    return 32'hDEAD_BEEF;
  endfunction

  // driver side of the scoreboard
  task automatic expectBoot(input logic [31:0] pc, input logic [31:0] sp);
    bootExp_t e;
    pcVec = pc; spVec = sp;
    e.pc = pc; e.sp = sp;
    expAddr.push_back(32'h0);
    expAddr.push_back(32'h4);
    expRun.push_back(e);
  endtask

  task automatic pinPulse(input int n);
    @(negedge clk); rstPinN = 1'b0;
    repeat (n) @(negedge clk);
    rstPinN = 1'b1;
  endtask

  task automatic dbgPulse(input int gap);
    @(negedge clk); dbgRstAssert = 1'b1;
    @(negedge clk); dbgRstAssert = 1'b0;
    repeat (gap - 1) @(negedge clk);
    dbgRstNegate = 1'b1;
    @(negedge clk); dbgRstNegate = 1'b0;
  endtask

  task automatic waitDrain(input string req);
    int n = 0;
    while ((expRun.size() != 0) && (n < 200)) begin
      @(negedge clk); n++;
    end
    chkEq(req, 32'(expRun.size()), 32'd0);
  endtask

  // responder and monitor: act 1 ns after each falling edge
  initial begin
    int waitCnt = 0;
    logic prevRun = 1'b0;
    logic [31:0] ea;
    bootExp_t e;
    forever begin
      @(negedge clk); #1;
      if (rdReady) begin
        rdReady = 1'b0; waitCnt = 0;
      end else if (rdValid) begin
        if (waitCnt >= delay) begin
          if (expAddr.size() == 0) begin
            chkEq("R2 unexpected read", rdAddr, 32'hFFFF_FFFF);
          end else begin
            ea = expAddr.pop_front();
            chkEq("R3 read address", rdAddr, ea);
          end
          rdData  = memWord(rdAddr);
          rdReady = 1'b1;
        end else begin
          waitCnt++;
        end
      end else begin
        waitCnt = 0;
      end
      if (runEnable && !prevRun) begin
        if (expRun.size() == 0) begin
          chkEq("R6 unexpected run", 32'd1, 32'd0);
        end else begin
          e = expRun.pop_front();
          chkEq("R3 pc at run", pcOut, e.pc);
          chkEq("R6 sp at run", spOut, e.sp);
          chkEq("R5 vbr", vbrOut, 32'h0);
          chkEq("R5 mask", 32'(srMaskOut), 32'hF);
          chkEq("R5 bank", 32'(bankBitOut), 32'h0);
          chkEq("R5 fpscr", fpscrOut, 32'h0004_0001);
        end
      end
      prevRun = runEnable;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // reset state, pin held low from time zero
    repeat (25) @(negedge clk);
    #2;
    chkEq("R1 run in reset", 32'(runEnable), 32'h0);
    chkEq("R1 rdValid in reset", 32'(rdValid), 32'h0);
    chkEq("R1 pc in reset", pcOut, 32'h0);
    chkEq("R1 sp in reset", spOut, 32'h0);
    chkEq("R5 fpscr in reset", fpscrOut, 32'h0004_0001);
    chkEq("R5 mask in reset", 32'(srMaskOut), 32'hF);
    expectBoot(32'h1000_0100, 32'h2000_FFF0);
    rstPinN = 1'b1;
    waitDrain("R2 boot after long pin reset");

    // pin drop stops the core at once, then a short pulse is rejected
    @(negedge clk); rstPinN = 1'b0; #1;
    chkEq("R1 run falls with pin", 32'(runEnable), 32'h0);
    repeat (16) @(negedge clk);
    rstPinN = 1'b1;
    repeat (40) @(negedge clk);
    chkEq("R2 short pulse no run", 32'(runEnable), 32'h0);
    chkEq("R2 short pulse pc", pcOut, 32'h0);

    // exact minimum, with wait states
    delay = 3;
    expectBoot(32'h0000_4000, 32'h0000_8000);
    pinPulse(20);
    waitDrain("R4 boot with wait states at minimum hold");

    // debug path: one edge short, then exact minimum
    delay = 0;
    dbgPulse(19);
    repeat (40) @(negedge clk);
    chkEq("R7 short debug no run", 32'(runEnable), 32'h0);
    expectBoot(32'hA5A5_0000, 32'h5A5A_1110);
    dbgPulse(20);
    waitDrain("R7 debug boot");

    // abort during PC fetch by the pin
    delay = 6;
    pinPulse(25);
    while (!rdValid) @(negedge clk);
    chkEq("R3 first addr", rdAddr, 32'h0);
    rstPinN = 1'b0;
    repeat (4) @(negedge clk);
    #2;
    chkEq("R8 abort rdValid", 32'(rdValid), 32'h0);
    chkEq("R8 abort run", 32'(runEnable), 32'h0);
    expectBoot(32'h0BAD_F00D, 32'h0000_7FFC);
    repeat (22) @(negedge clk);
    rstPinN = 1'b1;
    waitDrain("R8 boot after pin abort");

    // abort during SP fetch by a debug command
    begin
      bootExp_t tmp;
      pcVec = 32'h1234_5678; spVec = 32'h8765_4320;
      expAddr.push_back(32'h0);
      pinPulse(25);
      while (!(rdValid && rdAddr == 32'h4)) @(negedge clk);
      #2;
      chkEq("R3 pc before sp", pcOut, 32'h1234_5678);
      dbgRstAssert = 1'b1;
      @(negedge clk); dbgRstAssert = 1'b0;
      repeat (2) @(negedge clk);
      #2;
      chkEq("R8 sp abort rdValid", 32'(rdValid), 32'h0);
      chkEq("R8 sp abort pc", pcOut, 32'h0);
      chkEq("R8 sp abort run", 32'(runEnable), 32'h0);
      tmp.pc = 32'h1234_5678; tmp.sp = 32'h8765_4320;
      expAddr.push_back(32'h0); expAddr.push_back(32'h4);
      expRun.push_back(tmp);
      repeat (20) @(negedge clk);
      dbgRstNegate = 1'b1;
      @(negedge clk); dbgRstNegate = 1'b0;
      waitDrain("R8 boot after debug abort");
    end

    repeat (5) @(negedge clk);
    chkEq("R3 no leftover reads", 32'(expAddr.size()), 32'd0);
    chkEq("R6 run held", 32'(runEnable), 32'h1);
    finishRun();
  end
endmodule